// File: doc/BRIEF.md
# Serial Word Transmitter

This block takes 32-bit words from an upstream queue and sends each one out as a serial bit stream, one bit per bit period. The bit period is 10 or 80 input clocks, chosen by a rate-select pin. The eight label bits go first, from bit 8 down to bit 1. The remaining bits follow in ascending order, bit 9 through bit 32. Bit 32 is either the word's own top bit, or a parity bit the block generates, with odd or even sense.

Each bit is presented on a data line together with a one-cycle strobe that marks the start of the bit. After bit 32 the line stays low for four bit periods before the block takes another word. A mode pin steers the data line and its strobe either to the line outputs or to a separate loopback pair, which feeds the receive side for self-test.

The word input is a valid/ready stream. `in_ready` is high only while the block is idle. A word is taken on a clock edge where both `in_valid` and `in_ready` are high, and that handshake is the pop from the upstream queue. The source may hold `in_valid` and `in_data` for as long as it likes; nothing is taken while `in_ready` is low. When no word is offered, the block stays idle and sends nothing.

Top module: `wordser_tx`

## Requirements
- R1: While reset is held and directly after it, `in_ready` is 1 and `line_data`, `line_stb`, `loop_data` and `loop_stb` are all 0.
- R2: Transmit order is `in_data[7]`, `in_data[6]` … `in_data[0]`, then `in_data[8]`, `in_data[9]` … `in_data[30]`, then the 32nd bit.
- R3: Every bit lasts exactly 10 clocks when `cfg_slow`=0, or 80 clocks when `cfg_slow`=1. A one-cycle strobe marks the start of each bit. The first strobe comes in the cycle after the handshake, and strobes never come closer than 10 clocks apart.
- R4: With `cfg_par_en`=0, the 32nd bit sent is `in_data[31]`.
- R5: With `cfg_par_en`=1 and `cfg_par_even`=0, the 32nd bit is chosen so that the 32 bits sent contain an odd number of ones. `in_data[31]` has no effect.
- R6: With `cfg_par_en`=1 and `cfg_par_even`=1, the 32nd bit is chosen so that the 32 bits sent contain an even number of ones.
- R7: After the 32nd bit's period, the data outputs stay 0 with no strobe for four bit periods. The first strobe of the next word comes at least five bit periods after the previous word's last strobe.
- R8: `in_ready` is 0 from the cycle after a handshake until the gap has ended. Exactly one word is sent per handshake. No strobe appears when no word has been offered, and while idle all outputs are 0.
- R9: With `cfg_normal`=1, bits and strobes appear only on `line_data`/`line_stb`, and the loop outputs stay 0. With `cfg_normal`=0, the reverse holds.
- R10: `cfg_slow`, `cfg_par_en` and `cfg_par_even` are sampled at the handshake. Changing them while a word is being sent has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered by the upstream queue |
| in_ready | output | 1 | Block idle and able to take a word |
| in_data | input | 32 | Word to send; bit 0 is word bit 1 |
| cfg_slow | input | 1 | 0: bit period 10 clocks, 1: 80 clocks |
| cfg_par_en | input | 1 | 1: 32nd bit replaced by generated parity |
| cfg_par_even | input | 1 | Parity sense, 0 odd, 1 even |
| cfg_normal | input | 1 | 1: line outputs, 0: loopback outputs |
| line_data | output | 1 | Serial data toward the line |
| line_stb | output | 1 | Start-of-bit strobe toward the line |
| loop_data | output | 1 | Serial data routed back to the receivers |
| loop_stb | output | 1 | Start-of-bit strobe routed back |

## Verification
The bench uses the default parameters: fast divisor 10, slow divisor 80 and a four-bit gap. With these values a slow-rate word takes about 2900 clocks, so words at both rates fit in one run. Back-to-back words check the exact spacing between strobes within a word and the minimum gap between words. Configuration is changed in the middle of a word to show that sampling at the handshake keeps rate and parity fixed for that word. Loopback is exercised between drained phases, so the checks on routing never see a mode change mid-word.

// File: rtl/wordser_pkg.sv
package wordser_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DATA = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;

  // Value of the final bit that gives the chosen total count of ones,
  // given the reduction XOR of all other bits.
  function automatic logic parity_fill(input logic rest_xor, input logic want_even);
    return rest_xor ^ ~want_even;
  endfunction

endpackage

// File: rtl/wordser_framer.sv
module wordser_framer #(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic              par_en,
  input  logic              par_even,
  output logic [WORD_W-1:0] frame
);
  import wordser_pkg::*;

  localparam int BODY_LO = LABEL_W;
  localparam int LAST    = WORD_W - 1;

  logic fill;
  assign fill = parity_fill(^word[LAST-1:0], par_even);

  // frame[0] leaves first: label reversed, body in order, final bit last
  for (genvar i = 0; i < LABEL_W; i++) begin : g_label
    assign frame[i] = word[LABEL_W-1-i];
  end

  for (genvar i = BODY_LO; i < LAST; i++) begin : g_body
    assign frame[i] = word[i];
  end

  assign frame[LAST] = par_en ? fill : word[LAST];

endmodule

// File: rtl/wordser_pacer.sv
module wordser_pacer #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow_in,
  output logic tick
);
  localparam int CW = $clog2(DIV_SLOW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          slow_q;

  assign lim  = slow_q ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
  assign tick = (cnt == lim) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      slow_q <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      slow_q <= slow_in;
    end else if (cnt == lim) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wordser_seq.sv
module wordser_seq #(
  parameter int WORD_W   = 32,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] frame,
  input  logic              tick,
  output logic              restart,
  output logic              ser_bit,
  output logic              ser_stb
);
  import wordser_pkg::*;

  localparam int SLOTS = WORD_W + GAP_BITS;
  localparam int SW    = $clog2(SLOTS);

  seq_state_t        state;
  logic [SW-1:0]     slot;
  logic [WORD_W-1:0] shreg;
  logic              accept;

  assign in_ready = (state == SEQ_IDLE);
  assign accept   = in_valid && in_ready;
  assign restart  = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      slot    <= '0;
      shreg   <= '0;
      ser_bit <= 1'b0;
      ser_stb <= 1'b0;
    end else begin
      ser_stb <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            shreg   <= frame >> 1;
            ser_bit <= frame[0];
            ser_stb <= 1'b1;
            slot    <= '0;
            state   <= SEQ_DATA;
          end
        end
        SEQ_DATA: begin
          if (tick) begin
            slot <= slot + 1'b1;
            if (slot == SW'(WORD_W - 1)) begin
              ser_bit <= 1'b0;
              state   <= SEQ_GAP;
            end else begin
              ser_bit <= shreg[0];
              shreg   <= shreg >> 1;
              ser_stb <= 1'b1;
            end
          end
        end
        SEQ_GAP: begin
          if (tick) begin
            if (slot == SW'(SLOTS - 1)) begin
              slot  <= '0;
              state <= SEQ_IDLE;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wordser_route.sv
module wordser_route (
  input  logic normal,
  input  logic ser_bit,
  input  logic ser_stb,
  output logic line_data,
  output logic line_stb,
  output logic loop_data,
  output logic loop_stb
);
  assign line_data = ser_bit &  normal;
  assign line_stb  = ser_stb &  normal;
  assign loop_data = ser_bit & ~normal;
  assign loop_stb  = ser_stb & ~normal;
endmodule

// File: rtl/wordser_tx.sv
module wordser_tx #(
  parameter int WORD_W   = 32,
  parameter int LABEL_W  = 8,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              cfg_slow,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_normal,
  output logic              line_data,
  output logic              line_stb,
  output logic              loop_data,
  output logic              loop_stb
);
  logic [WORD_W-1:0] frame;
  logic              tick;
  logic              restart;
  logic              ser_bit;
  logic              ser_stb;

  wordser_framer #(.WORD_W(WORD_W), .LABEL_W(LABEL_W)) u_framer (
    .word     (in_data),
    .par_en   (cfg_par_en),
    .par_even (cfg_par_even),
    .frame    (frame)
  );

  wordser_pacer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .slow_in (cfg_slow),
    .tick    (tick)
  );

  wordser_seq #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .frame    (frame),
    .tick     (tick),
    .restart  (restart),
    .ser_bit  (ser_bit),
    .ser_stb  (ser_stb)
  );

  wordser_route u_route (
    .normal    (cfg_normal),
    .ser_bit   (ser_bit),
    .ser_stb   (ser_stb),
    .line_data (line_data),
    .line_stb  (line_stb),
    .loop_data (loop_data),
    .loop_stb  (loop_stb)
  );

endmodule

// File: rtl/wordser_tx_chk.sv
module wordser_tx_chk #(
  parameter int DIV_FAST = 10
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_normal,
  input logic line_data,
  input logic line_stb,
  input logic loop_data,
  input logic loop_stb
);
  localparam int GW = $clog2(DIV_FAST + 1);

  logic          any_stb;
  logic          seen_stb;
  logic [GW-1:0] since;

  assign any_stb = line_stb || loop_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= '0;
      seen_stb <= 1'b0;
    end else if (any_stb) begin
      since    <= '0;
      seen_stb <= 1'b1;
    end else if (since < GW'(DIV_FAST)) begin
      since <= since + 1'b1;
    end
  end

  a_r9_single_route: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_stb && loop_stb) && !(line_data && loop_data));

  a_r9_route_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb |-> cfg_normal) and (loop_stb |-> !cfg_normal));

  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (line_stb || loop_stb));

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !(line_stb || loop_stb || line_data || loop_data));

  a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && seen_stb) |-> (since >= GW'(DIV_FAST - 1)));

endmodule

bind wordser_tx wordser_tx_chk #(.DIV_FAST(DIV_FAST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cfg_normal (cfg_normal),
  .line_data  (line_data),
  .line_stb   (line_stb),
  .loop_data  (loop_data),
  .loop_stb   (loop_stb)
);

// File: tb/wordser_tx_bench.sv
module wordser_tx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        cfg_slow = 1'b0;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_even = 1'b0;
  logic        cfg_normal = 1'b1;
  logic        line_data, line_stb, loop_data, loop_stb;

  always #4 clk = ~clk;

  wordser_tx u_wordser_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_slow(cfg_slow), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_normal(cfg_normal),
    .line_data(line_data), .line_stb(line_stb),
    .loop_data(loop_data), .loop_stb(loop_stb)
  );

  typedef struct {
    logic [31:0] bits;
    int          period;
    logic        loopb;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   stray  = 0;
  bit   done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] serial_of(input logic [31:0] d, input logic pen,
                                            input logic peven);
    logic [31:0] s;
    int ones;
    for (int i = 0; i < 8; i++) s[i] = d[7-i];
    for (int i = 8; i < 31; i++) s[i] = d[i];
    ones = $countones(d[30:0]);
    if (!pen) s[31] = d[31];
    else if (peven) s[31] = ones[0];
    else s[31] = ~ones[0];
    return s;
  endfunction

  // Driver: offers a word, records the expectation at the handshake
  task automatic send(input logic [31:0] d, input string tag);
    exp_t e;
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    e.bits   = serial_of(d, cfg_par_en, cfg_par_even);
    e.period = cfg_slow ? 80 : 10;
    e.loopb  = !cfg_normal;
    e.tag    = tag;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R8", "ready after handshake", in_ready, 0);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (5 * 80 + 5) @(negedge clk);
  endtask

  // Monitor
  int          cyc = 0;
  int          last_stb = 0;
  int          nbits = 0;
  int          prev_period = 0;
  bit          have_prev = 0;
  bit          gap_bad = 0;
  bit          space_bad = 0;
  bit          route_bad = 0;
  int          bad_space = 0;
  logic [31:0] acc = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (line_stb || loop_stb) begin
        if (q.size() == 0) begin
          stray++;
        end else begin
          if (q[0].loopb ? (!loop_stb || line_stb) : (!line_stb || loop_stb))
            route_bad = 1;
          if (nbits > 0) begin
            if (cyc - last_stb != q[0].period) begin
              space_bad = 1;
              bad_space = cyc - last_stb;
            end
          end else if (have_prev) begin
            check(cyc - last_stb >= 5 * prev_period, "R7", "word gap",
                  cyc - last_stb, 5 * prev_period);
            check(!gap_bad, "R7", "line low in gap", gap_bad, 0);
          end
          acc[nbits] = line_data | loop_data;
          nbits++;
          last_stb = cyc;
          if (nbits == 32) begin
            check(acc == q[0].bits, q[0].tag, "serial word", acc, q[0].bits);
            check(!space_bad, "R3", "bit period", bad_space, q[0].period);
            check(!route_bad, "R9", "output route", route_bad, 0);
            prev_period = q[0].period;
            have_prev = 1;
            void'(q.pop_front());
            nbits = 0; gap_bad = 0; space_bad = 0; route_bad = 0;
          end
        end
      end else if (have_prev && nbits == 0 && cyc - last_stb >= prev_period) begin
        if (line_data | loop_data) gap_bad = 1;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: actual=timeout expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
    check({line_data, line_stb, loop_data, loop_stb} == 4'b0, "R1", "outputs in reset",
          {line_data, line_stb, loop_data, loop_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && !line_stb && !line_data, "R1", "after reset",
          {in_ready, line_stb, line_data}, 3'b100);

    // R2, R4: ordering with bit 32 as data, back to back words (R7)
    send(32'h8000_0001, "R2");
    send(32'h0000_00C3, "R2");
    send(32'h5A5A_A500, "R4");
    send(32'h7FFF_FF80, "R4");

    // R5: odd parity; in_data[31] ignored
    cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    send(32'h0000_0000, "R5");
    send(32'h8000_0000, "R5");
    send(32'h7FFF_FFFF, "R5");
    send(32'h1234_5678, "R5");

    // R6: even parity
    cfg_par_even = 1'b1;
    send(32'h0000_0000, "R6");
    send(32'hFFFF_FFFF, "R6");
    send(32'h0F0F_0E01, "R6");
    drain();

    // R3: slow rate
    cfg_slow = 1'b1; cfg_par_en = 1'b0;
    send(32'hDEAD_BEEF, "R3");
    send(32'h0000_0101, "R3");
    drain();

    // R10: config changes mid-word
    cfg_slow = 1'b0; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    send(32'h0000_0007, "R10");
    repeat (30) @(negedge clk);
    cfg_slow = 1'b1; cfg_par_even = 1'b1; cfg_par_en = 1'b0;
    drain();
    cfg_slow = 1'b0; cfg_par_en = 1'b1; cfg_par_even = 1'b0;

    // R9: loopback routing
    cfg_normal = 1'b0;
    send(32'hA5A5_5A5A, "R9");
    send(32'h0000_00FF, "R9");
    drain();
    cfg_normal = 1'b1;
    send(32'h3C3C_C3C3, "R9");
    drain();

    // R8: nothing offered, nothing sent
    repeat (600) @(negedge clk);
    check(in_ready == 1'b1, "R8", "idle ready", in_ready, 1);
    check(stray == 0, "R8", "strobes without word", stray, 0);
    check(q.size() == 0, "R8", "words left unsent", q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule